// File: doc/BRIEF.md
# Idle-Exit Wake Controller

This block supervises the way a small processor subsystem leaves its low-power idle state. Once software requests idle, the block stops the clock-generator enable and watches a non-maskable interrupt line, a set of maskable interrupt requests and a synchronous reset request. Any unmasked source ends idle at once, whatever its priority. The block then waits out a programmable oscillator setup interval. When that interval ends it reports how execution must continue.

The continuation decision is made in the cycle that idle ends. A non-maskable interrupt is always taken. A maskable request is taken only when interrupts are globally enabled and, if idle was entered from inside a service routine, only when its priority is strictly above the priority being served. A request that is not taken does not vanish. It stays latched as pending, and the reported action is "continue with the next instruction". A reset request at any time puts the block back into its power-on state.

Top module: `wake_release_ctrl`

## Requirements
- R1: When running, a cycle with `idle_req` high makes `idle_o` high from the next cycle, and `pll_en` is low for every cycle in which `idle_o` is high.
- R2: An NMI pulse with `nmi_mask` low ends idle at the next clock edge. With `nmi_mask` high the NMI leaves the block idle.
- R3: A maskable request ends idle only if its `irq_mask` bit is 0, regardless of its priority. Masked requests leave the block idle but are still latched in `pend_o`.
- R4: With setup value S, `wake_done` rises exactly S+1 cycles after `idle_o` falls for an interrupt wake, and it stays high for exactly one cycle.
- R5: When a maskable request wakes the block with `int_en` low, `resume_code` is 2 (next instruction). `ack` stays low and the request bit stays set in `pend_o`.
- R6: When a maskable request wakes the block with `int_en` high and `in_service` low, `resume_code` is 1 (branch to handler). `ack` pulses with `wake_done`, `ack_id` gives the request index, and that bit is cleared from `pend_o`.
- R7: When `in_service` and `int_en` are both high, a waking request whose priority value is not greater than `svc_prio` gives code 2 with no ack and remains pending. A strictly greater priority gives code 1 with an ack. A larger value means a higher priority.
- R8: A waking unmasked NMI gives code 1 and pulses `ack` together with `ack_nmi`, whatever the values of `int_en`, `in_service` and the priorities. Maskable requests that arrive at the same time remain pending.
- R9: When several unmasked requests wake the block together, the lowest index is the one considered for acknowledge. All other bits remain in `pend_o`.
- R10: A cycle with `rst_req` high returns the block to its power-on state on the next cycle: `idle_o` is 0, `wake_done` is 0, `ack` is 0, `pend_o` is 0 (requests in that same cycle are discarded), and `resume_code` is 3 (reset).
- R11: After an interrupt wake and up to `wake_done`, `pll_en` equals the value that `pll_cfg` had in the last running cycle before idle, even if `pll_cfg` changed while the block was idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req | input | 1 | Synchronous reset request, also a wake source |
| idle_req | input | 1 | Request to enter idle |
| pll_cfg | input | 1 | Clock-generator enable wanted while running |
| nmi | input | 1 | Non-maskable interrupt request |
| nmi_mask | input | 1 | 1 disables the NMI as a wake source |
| irq_req | input | N_IRQ | Maskable interrupt requests |
| irq_mask | input | N_IRQ | 1 masks the matching request |
| irq_prio | input | N_IRQ*PRIO_W | Packed priority per request, index i at bits [i*PRIO_W +: PRIO_W] |
| svc_prio | input | PRIO_W | Priority of the routine in service |
| in_service | input | 1 | Idle was entered inside a service routine |
| int_en | input | 1 | Global maskable interrupt enable |
| setup_val | input | CNT_W | Setup interval in cycles |
| idle_o | output | 1 | Idle state active |
| pll_en | output | 1 | Clock-generator enable |
| wake_done | output | 1 | One-cycle pulse when resume is reported |
| resume_code | output | 2 | 1 branch, 2 next instruction, 3 reset |
| ack | output | 1 | Acknowledge strobe |
| ack_nmi | output | 1 | Acknowledge is for the NMI |
| ack_id | output | $clog2(N_IRQ) | Index of the acknowledged request |
| pend_o | output | N_IRQ | Latched pending requests |

## Verification
A corrupted decision register would show up in the `wake_done` cycle as a wrong `resume_code`, a wrong `ack` or `ack_id`, or a cleared bit in `pend_o` that should have stayed set. So every wake gives one cycle in which the stored choice can be compared against values computed independently. A counter that is off by even one cycle moves `wake_done` away from S+1, and the bench measures that distance directly. A state encoding that leaks out of idle shows up within one cycle on `idle_o` or on `pll_en`.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SETUP = 2'd2
    } wrc_state_e;

    typedef enum logic [1:0] {
        RES_NONE   = 2'd0,
        RES_BRANCH = 2'd1,
        RES_NEXT   = 2'd2,
        RES_RESET  = 2'd3
    } resume_e;
endpackage

// File: rtl/wrc_pick.sv
module wrc_pick #(
    parameter int N   = 8,
    parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]   req,
    input  logic [N-1:0]   mask,
    output logic           any,
    output logic [IDW-1:0] idx
);
    logic [N-1:0] live;

    assign live = req & ~mask;

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (live[i]) begin
                any = 1'b1;
                idx = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/wrc_setup_timer.sv
module wrc_setup_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R4
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (cnt_q == $past(load_val)));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/wake_release_ctrl.sv
module wake_release_ctrl
    import wrc_pkg::*;
#(
    parameter int N_IRQ  = 8,
    parameter int PRIO_W = 3,
    parameter int CNT_W  = 16,
    localparam int IDW   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rst_req,
    input  logic                    idle_req,
    input  logic                    pll_cfg,
    input  logic                    nmi,
    input  logic                    nmi_mask,
    input  logic [N_IRQ-1:0]        irq_req,
    input  logic [N_IRQ-1:0]        irq_mask,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]       svc_prio,
    input  logic                    in_service,
    input  logic                    int_en,
    input  logic [CNT_W-1:0]        setup_val,
    output logic                    idle_o,
    output logic                    pll_en,
    output logic                    wake_done,
    output logic [1:0]              resume_code,
    output logic                    ack,
    output logic                    ack_nmi,
    output logic [IDW-1:0]          ack_id,
    output logic [N_IRQ-1:0]        pend_o
);
    typedef struct packed {
        wrc_state_e       state;
        logic [N_IRQ-1:0] pend;
        logic             pll_save;
        resume_e          dec_act;
        logic             dec_ack;
        logic             dec_nmi;
        logic [IDW-1:0]   dec_id;
        resume_e          code;
        logic             done;
        logic             ack;
        logic             ack_nmi;
        logic [IDW-1:0]   ack_id;
    } wrc_regs_t;

    wrc_regs_t        r_d, r_q;
    logic [N_IRQ-1:0] pend_all;
    logic             pick_any;
    logic [IDW-1:0]   pick_idx;
    logic [PRIO_W-1:0] pick_prio;
    logic             nmi_wake;
    logic             tmr_load;
    logic             tmr_zero;

    assign pend_all  = r_q.pend | irq_req;
    assign nmi_wake  = nmi & ~nmi_mask;
    assign pick_prio = irq_prio[pick_idx*PRIO_W +: PRIO_W];

    wrc_pick #(.N(N_IRQ), .IDW(IDW)) u_pick (
        .req  (pend_all),
        .mask (irq_mask),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    wrc_setup_timer #(.CW(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rst_req),
        .load     (tmr_load),
        .load_val (setup_val),
        .zero_o   (tmr_zero)
    );

    always_comb begin
        r_d         = r_q;
        r_d.pend    = pend_all;
        r_d.done    = 1'b0;
        r_d.ack     = 1'b0;
        r_d.ack_nmi = 1'b0;
        tmr_load    = 1'b0;
        unique case (r_q.state)
            ST_RUN: begin
                r_d.pll_save = pll_cfg;
                if (idle_req)
                    r_d.state = ST_IDLE;
            end
            ST_IDLE: begin
                if (nmi_wake || pick_any) begin
                    r_d.state   = ST_SETUP;
                    tmr_load    = 1'b1;
                    r_d.dec_nmi = nmi_wake;
                    r_d.dec_id  = pick_idx;
                    if (nmi_wake) begin
                        r_d.dec_ack = 1'b1;
                        r_d.dec_act = RES_BRANCH;
                    end else if (!int_en) begin
                        r_d.dec_ack = 1'b0;
                        r_d.dec_act = RES_NEXT;
                    end else if (in_service && !(pick_prio > svc_prio)) begin
                        r_d.dec_ack = 1'b0;
                        r_d.dec_act = RES_NEXT;
                    end else begin
                        r_d.dec_ack = 1'b1;
                        r_d.dec_act = RES_BRANCH;
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    r_d.state   = ST_RUN;
                    r_d.done    = 1'b1;
                    r_d.code    = r_q.dec_act;
                    r_d.ack     = r_q.dec_ack;
                    r_d.ack_nmi = r_q.dec_ack & r_q.dec_nmi;
                    r_d.ack_id  = r_q.dec_nmi ? '0 : r_q.dec_id;
                    if (r_q.dec_ack && !r_q.dec_nmi)
                        r_d.pend[r_q.dec_id] = 1'b0;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
        if (rst_req) begin
            r_d      = '0;
            r_d.code = RES_RESET;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.code <= RES_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle_o      = (r_q.state == ST_IDLE);
    assign pll_en      = (r_q.state == ST_IDLE) ? 1'b0 : r_q.pll_save;
    assign wake_done   = r_q.done;
    assign resume_code = r_q.code;
    assign ack         = r_q.ack;
    assign ack_nmi     = r_q.ack_nmi;
    assign ack_id      = r_q.ack_id;
    assign pend_o      = r_q.pend;

    // R1
    idle_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_RUN && idle_req && !rst_req) |=> idle_o);

    // R3
    masked_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && !rst_req && !(nmi && !nmi_mask)
         && ((irq_req | pend_o) & ~irq_mask) == '0) |=> idle_o);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done);

    // R6
    ack_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (wake_done && resume_code == RES_BRANCH));

    // R8
    nmi_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_nmi |-> ack);

    // R10
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (!idle_o && !wake_done && !ack && pend_o == '0
                     && resume_code == RES_RESET));
endmodule

// File: tb/wake_release_ctrl_test.sv
`timescale 1ns/1ps
module wake_release_ctrl_test;
    localparam int N  = 4;
    localparam int PW = 2;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rst_req = 1'b0, idle_req = 1'b0, pll_cfg = 1'b0;
    logic          nmi = 1'b0, nmi_mask = 1'b0;
    logic [N-1:0]  irq_req = '0, irq_mask = '0;
    logic [N*PW-1:0] irq_prio = '0;
    logic [PW-1:0] svc_prio = '0;
    logic          in_service = 1'b0, int_en = 1'b0;
    logic [CW-1:0] setup_val = '0;
    logic          idle_o, pll_en, wake_done, ack, ack_nmi;
    logic [1:0]    resume_code;
    logic [1:0]    ack_id;
    logic [N-1:0]  pend_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    wake_release_ctrl #(.N_IRQ(N), .PRIO_W(PW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .idle_req(idle_req),
        .pll_cfg(pll_cfg), .nmi(nmi), .nmi_mask(nmi_mask), .irq_req(irq_req),
        .irq_mask(irq_mask), .irq_prio(irq_prio), .svc_prio(svc_prio),
        .in_service(in_service), .int_en(int_en), .setup_val(setup_val),
        .idle_o(idle_o), .pll_en(pll_en), .wake_done(wake_done),
        .resume_code(resume_code), .ack(ack), .ack_nmi(ack_nmi),
        .ack_id(ack_id), .pend_o(pend_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic soft_reset(input logic [N-1:0] junk);
        @(negedge clk);
        rst_req = 1'b1;
        irq_req = junk;
        @(negedge clk);
        rst_req = 1'b0;
        irq_req = '0;
        chk("R10", "idle after reset", int'(idle_o), 0);
        chk("R10", "done after reset", int'(wake_done), 0);
        chk("R10", "ack after reset", int'(ack), 0);
        chk("R10", "pend after reset", int'(pend_o), 0);
        chk("R10", "code after reset", int'(resume_code), 3);
    endtask

    function automatic int lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++)
            if (v[i]) return i;
        return 0;
    endfunction

    task automatic run_case(input logic [N-1:0] req, input logic [N-1:0] mask,
                            input logic nmi_v, input logic nmi_m,
                            input logic [N*PW-1:0] prios, input logic [PW-1:0] svc,
                            input logic insvc, input logic ien,
                            input int s, input logic pll_v, input string tag);
        logic [N-1:0] live;
        bit wake, exp_ack, exp_nmi;
        int exp_code, id, cnt;
        logic [N-1:0] exp_pend;
        soft_reset('0);
        irq_mask = mask; nmi_mask = nmi_m; irq_prio = prios; svc_prio = svc;
        in_service = insvc; int_en = ien; setup_val = CW'(s); pll_cfg = pll_v;
        @(negedge clk);
        idle_req = 1'b1;
        @(negedge clk);
        idle_req = 1'b0;
        pll_cfg  = ~pll_v;
        chk("R1", "idle entered", int'(idle_o), 1);
        chk("R1", "pll off in idle", int'(pll_en), 0);
        irq_req = req;
        nmi     = nmi_v;
        @(negedge clk);
        irq_req = '0;
        nmi     = 1'b0;
        live = req & ~mask;
        wake = (live != '0) || (nmi_v && !nmi_m);
        if (!wake) begin
            chk(tag, "stays idle", int'(idle_o), 1);
            repeat (3) @(negedge clk);
            chk(tag, "still idle", int'(idle_o), 1);
            chk(tag, "no done while idle", int'(wake_done), 0);
            chk("R3", "masked pending kept", int'(pend_o), int'(req));
            return;
        end
        id = lowest(live);
        exp_pend = req;
        exp_nmi = 1'b0;
        if (nmi_v && !nmi_m) begin
            exp_code = 1; exp_ack = 1'b1; exp_nmi = 1'b1;
        end else if (!ien) begin
            exp_code = 2; exp_ack = 1'b0;
        end else if (insvc && !(int'(prios[id*PW +: PW]) > int'(svc))) begin
            exp_code = 2; exp_ack = 1'b0;
        end else begin
            exp_code = 1; exp_ack = 1'b1;
            exp_pend[id] = 1'b0;
        end
        chk(tag, "left idle", int'(idle_o), 0);
        chk("R11", "pll restored in setup", int'(pll_en), int'(pll_v));
        cnt = 0;
        while (!wake_done && cnt < 1000) begin
            @(negedge clk);
            cnt++;
        end
        chk("R4", "setup length", cnt, s + 1);
        chk(tag, "resume code", int'(resume_code), exp_code);
        chk(tag, "ack", int'(ack), int'(exp_ack));
        chk("R8", "ack_nmi", int'(ack_nmi), int'(exp_nmi));
        if (exp_ack && !exp_nmi)
            chk("R9", "ack id", int'(ack_id), id);
        chk(tag, "pending after wake", int'(pend_o), int'(exp_pend));
        chk("R11", "pll at done", int'(pll_en), int'(pll_v));
        @(negedge clk);
        chk("R4", "done single cycle", int'(wake_done), 0);
        chk("R4", "ack single cycle", int'(ack), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "power-on idle", int'(idle_o), 0);
        chk("R10", "power-on done", int'(wake_done), 0);
        chk("R10", "power-on code", int'(resume_code), 3);
        chk("R10", "power-on pend", int'(pend_o), 0);
        chk("R1", "power-on pll", int'(pll_en), 0);

        // R5 R6 R7: single request over all priorities, service levels and enables
        for (int i = 0; i < N; i++)
            for (int p = 0; p < 4; p++)
                for (int sv = 0; sv < 4; sv++)
                    for (int is = 0; is < 2; is++)
                        for (int ie = 0; ie < 2; ie++) begin
                            logic [N*PW-1:0] pv;
                            string tg;
                            pv = '0;
                            pv[i*PW +: PW] = PW'(p);
                            tg = (ie == 0) ? "R5" : ((is != 0) ? "R7" : "R6");
                            run_case(N'(1 << i), '0, 1'b0, 1'b0, pv, PW'(sv),
                                     is[0], ie[0], (i + p) % 3, p[0], tg);
                        end

        // R3 R9: every request pattern against every mask
        for (int r = 1; r < 16; r++)
            for (int m = 0; m < 16; m++)
                run_case(N'(r), N'(m), 1'b0, 1'b0, 8'hE4, 2'd0, 1'b0, 1'b1,
                         0, 1'b1, "R3");

        // R2 R8: NMI with and without its mask, across enables and service state
        for (int rr = 0; rr < 2; rr++)
            for (int nm = 0; nm < 2; nm++)
                for (int ie = 0; ie < 2; ie++)
                    for (int is = 0; is < 2; is++)
                        run_case((rr != 0) ? 4'b0101 : 4'b0000, 4'b0000, 1'b1, nm[0],
                                 8'hFF, 2'd3, is[0], ie[0], 2, 1'b1,
                                 (nm != 0) ? "R2" : "R8");

        // R4: long setup interval
        run_case(4'b1000, 4'b0000, 1'b0, 1'b0, 8'h00, 2'd0, 1'b0, 1'b1,
                 300, 1'b0, "R6");

        // R10: reset request during idle and during setup, with requests present
        soft_reset('0);
        @(negedge clk);
        idle_req = 1'b1;
        @(negedge clk);
        idle_req = 1'b0;
        chk("R1", "idle before reset", int'(idle_o), 1);
        soft_reset(4'b1111);
        chk("R10", "reset wakes from idle", int'(idle_o), 0);
        irq_mask = '0; int_en = 1'b1; in_service = 1'b0; setup_val = 16'd20;
        @(negedge clk);
        idle_req = 1'b1;
        @(negedge clk);
        idle_req = 1'b0;
        irq_req = 4'b0010;
        @(negedge clk);
        irq_req = '0;
        chk("R3", "woke into setup", int'(idle_o), 0);
        soft_reset(4'b0100);
        repeat (25) begin
            @(negedge clk);
            chk("R10", "no done after reset in setup", int'(wake_done), 0);
        end

        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule